// File: doc/BRIEF.md
# Grouped Lookahead Adder/Subtractor

A purely combinational two's-complement adder/subtractor for a word of `WIDTH` bits (8 by default). The word is divided into lookahead groups of `GROUP_W` bits (4 by default).

Inside a group, each bit forms a generate term (both operand bits set) and a propagate term (operand bits differ). Every carry in that group is then a flat sum of products over those terms and the group's carry-in, so no carry waits on the carry of the bit below it. Between groups the carry ripples: the top carry of one group is the carry-in of the next group up. Each sum bit is the bit's propagate term XOR the carry arriving at that bit.

A mode input selects addition or subtraction. In add mode the external carry-in is used as given. In subtract mode the second operand is inverted bit by bit and the carry-in is forced high, which forms `a + ~b + 1`. A signed overflow flag is produced as the XOR of the carry into the most significant bit and the carry out of it. The block is meant to sit in an ALU datapath between operand registers and a result register.

Top module: `cla_addsub`

## Requirements
- R1: With `sub_sel`=0, `sum_out` equals (`op_a` + `op_b` + `carry_in`) modulo 2^WIDTH.
- R2: With `sub_sel`=0, `carry_out` equals bit WIDTH of the unsigned sum `op_a` + `op_b` + `carry_in`.
- R3: With `sub_sel`=1, `sum_out` equals (`op_a` − `op_b`) modulo 2^WIDTH, and `carry_in` has no effect on any output.
- R4: With `sub_sel`=1, `carry_out` is 1 exactly when `op_a` ≥ `op_b` taken as unsigned numbers (a set carry means no borrow).
- R5: `ovf_out` is 1 exactly when the true signed result (`op_a` + `op_b` + `carry_in` in add mode, `op_a` − `op_b` in subtract mode, with operands read as two's complement) lies outside [−2^(WIDTH−1), 2^(WIDTH−1)−1].
- R6: When the sign bit of `op_a` differs from the sign bit of the effective second operand (`op_b` in add mode, `~op_b` in subtract mode), `ovf_out` is 0.
- R7: A carry generated in the lower group reaches the upper group within the same evaluation. For example, 0x0F + 0x01 gives 0x10, and 0xFF + 0x00 with `carry_in`=1 gives 0x00 with `carry_out`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand (subtrahend in subtract mode) |
| carry_in | input | 1 | Carry into bit 0; used only in add mode |
| sub_sel | input | 1 | 0 = add, 1 = subtract |
| sum_out | output | WIDTH | Sum or difference |
| carry_out | output | 1 | Carry out of the most significant bit |
| ovf_out | output | 1 | Signed overflow |

## Verification
The main function is first tried with hand-picked vectors, each chosen to separate one behaviour:
- a carry that crosses only the group boundary;
- a carry that ripples through all eight bits;
- positive and negative overflow in both modes;
- mixed-sign cases that must never overflow;
- subtraction with `carry_in` raised, to show that `carry_in` is ignored.

After that, every combination of both operands is applied in add mode with each `carry_in` value and in subtract mode. This full sweep tells a wrong product term in any single lookahead carry apart from a wrong link between the groups, and both of those apart from an overflow flag built from the wrong pair of carries.

// File: rtl/cla_pkg.sv
package cla_pkg;

    // Generate and propagate terms of one bit position
    typedef struct packed {
        logic gen;
        logic prop;
    } gp_t;

endpackage

// File: rtl/cla_bit_gp.sv
module cla_bit_gp
    import cla_pkg::*;
(
    input  logic x_i,
    input  logic y_i,
    output gp_t  gp_o
);

    gp_t gp_d;

    always_comb begin
        gp_d      = '0;
        gp_d.gen  = x_i & y_i;
        gp_d.prop = x_i ^ y_i;
    end

    assign gp_o = gp_d;

endmodule

// File: rtl/cla_group.sv
module cla_group
    import cla_pkg::*;
#(
    parameter int GW = 4
) (
    input  logic [GW-1:0] x_i,
    input  logic [GW-1:0] y_i,
    input  logic          cin_i,
    output logic [GW-1:0] s_o,
    output logic [GW:0]   c_o
);

    gp_t [GW-1:0] gp_bits;

    for (genvar k = 0; k < GW; k++) begin : g_bit
        cla_bit_gp i_gp (
            .x_i  (x_i[k]),
            .y_i  (y_i[k]),
            .gp_o (gp_bits[k])
        );
    end

    logic [GW:0]   car_d;
    logic [GW-1:0] sum_d;

    // Each carry is a flat sum of products over this group's terms and cin_i;
    // no carry is built from another carry.
    always_comb begin
        car_d    = '0;
        car_d[0] = cin_i;
        for (int i = 0; i < GW; i++) begin
            logic acc;
            logic term;
            acc = 1'b0;
            for (int j = 0; j <= i; j++) begin
                term = gp_bits[j].gen;
                for (int k = j + 1; k <= i; k++) begin
                    term = term & gp_bits[k].prop;
                end
                acc = acc | term;
            end
            term = cin_i;
            for (int k = 0; k <= i; k++) begin
                term = term & gp_bits[k].prop;
            end
            car_d[i+1] = acc | term;
        end
    end

    always_comb begin
        for (int i = 0; i < GW; i++) begin
            sum_d[i] = gp_bits[i].prop ^ car_d[i];
        end
    end

    assign s_o = sum_d;
    assign c_o = car_d;

endmodule

// File: rtl/cla_addsub.sv
module cla_addsub #(
    parameter int WIDTH   = 8,
    parameter int GROUP_W = 4
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             carry_in,
    input  logic             sub_sel,
    output logic [WIDTH-1:0] sum_out,
    output logic             carry_out,
    output logic             ovf_out
);

    localparam int NGRP = WIDTH / GROUP_W;

    logic [WIDTH-1:0] b_eff;
    logic             c_first;

    always_comb begin
        b_eff   = sub_sel ? ~op_b : op_b;
        c_first = sub_sel ? 1'b1 : carry_in;
    end

    logic [NGRP:0]      grp_link;
    logic [GROUP_W:0]   grp_car [NGRP];
    logic [WIDTH-1:0]   sum_all;
    logic [WIDTH:0]     car_all;

    assign grp_link[0] = c_first;

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        cla_group #(.GW(GROUP_W)) i_grp (
            .x_i   (op_a [g*GROUP_W +: GROUP_W]),
            .y_i   (b_eff[g*GROUP_W +: GROUP_W]),
            .cin_i (grp_link[g]),
            .s_o   (sum_all[g*GROUP_W +: GROUP_W]),
            .c_o   (grp_car[g])
        );
        // ripple link between groups
        assign grp_link[g+1] = grp_car[g][GROUP_W];
        for (genvar k = 0; k < GROUP_W; k++) begin : g_tap
            assign car_all[g*GROUP_W + k] = grp_car[g][k];
        end
    end

    assign car_all[WIDTH] = grp_link[NGRP];

    assign sum_out   = sum_all;
    assign carry_out = car_all[WIDTH];
    assign ovf_out   = car_all[WIDTH] ^ car_all[WIDTH-1];

endmodule

// File: rtl/cla_addsub_chk.sv
module cla_addsub_chk #(
    parameter int WIDTH = 8
) (
    input logic [WIDTH-1:0] op_a,
    input logic [WIDTH-1:0] op_b,
    input logic             carry_in,
    input logic             sub_sel,
    input logic [WIDTH-1:0] sum_out,
    input logic             carry_out,
    input logic             ovf_out
);

    logic [WIDTH:0] uadd;
    logic [WIDTH:0] sa;
    logic [WIDTH:0] sb;
    logic [WIDTH:0] sres;
    logic           sign_mix;

    always_comb begin
        uadd     = {1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in};
        sa       = {op_a[WIDTH-1], op_a};
        sb       = {op_b[WIDTH-1], op_b};
        sres     = sub_sel ? (sa - sb) : (sa + sb + {{WIDTH{1'b0}}, carry_in});
        sign_mix = op_a[WIDTH-1] ^ (op_b[WIDTH-1] ^ sub_sel);
    end

    always_comb begin
        if (!sub_sel) begin
            // R1
            add_sum_chk: assert (sum_out == uadd[WIDTH-1:0]);
            // R2
            add_cout_chk: assert (carry_out == uadd[WIDTH]);
        end else begin
            // R3
            sub_diff_chk: assert (sum_out == op_a - op_b);
            // R4
            sub_borrow_chk: assert (carry_out == (op_a >= op_b));
        end
        // R5
        signed_ovf_chk: assert (ovf_out == (sres[WIDTH] != sres[WIDTH-1]));
        // R6
        mixed_sign_chk: assert (!(sign_mix && ovf_out));
    end

endmodule

bind cla_addsub cla_addsub_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/test_cla_addsub.sv
module test_cla_addsub;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 8;
    localparam int NVEC       = 15;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic         carry_in = 1'b0;
    logic         sub_sel = 1'b0;
    logic [W-1:0] sum_out;
    logic         carry_out;
    logic         ovf_out;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cla_addsub #(.WIDTH(W), .GROUP_W(4)) i_cla_addsub (
        .op_a      (op_a),
        .op_b      (op_b),
        .carry_in  (carry_in),
        .sub_sel   (sub_sel),
        .sum_out   (sum_out),
        .carry_out (carry_out),
        .ovf_out   (ovf_out)
    );

    // {sub, cin, a, b, exp_sum, exp_cout, exp_ovf}
    localparam logic [27:0] VEC [NVEC] = '{
        {1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0},  // R1 zero
        {1'b0, 1'b0, 8'h0F, 8'h01, 8'h10, 1'b0, 1'b0},  // R7 group boundary
        {1'b0, 1'b1, 8'hFF, 8'h00, 8'h00, 1'b1, 1'b0},  // R7 R2 full ripple
        {1'b0, 1'b0, 8'h7F, 8'h01, 8'h80, 1'b0, 1'b1},  // R5 positive ovf
        {1'b0, 1'b0, 8'h80, 8'h80, 8'h00, 1'b1, 1'b1},  // R5 negative ovf
        {1'b0, 1'b1, 8'h7F, 8'h80, 8'h00, 1'b1, 1'b0},  // R6 mixed signs
        {1'b0, 1'b0, 8'h64, 8'h64, 8'hC8, 1'b0, 1'b1},  // R5 100+100
        {1'b1, 1'b0, 8'h05, 8'h03, 8'h02, 1'b1, 1'b0},  // R3 R4
        {1'b1, 1'b0, 8'h03, 8'h05, 8'hFE, 1'b0, 1'b0},  // R4 borrow
        {1'b1, 1'b1, 8'h05, 8'h03, 8'h02, 1'b1, 1'b0},  // R3 cin ignored
        {1'b1, 1'b0, 8'h80, 8'h01, 8'h7F, 1'b1, 1'b1},  // R5 -128-1
        {1'b1, 1'b0, 8'h7F, 8'hFF, 8'h80, 1'b0, 1'b1},  // R5 127-(-1)
        {1'b1, 1'b0, 8'h00, 8'h00, 8'h00, 1'b1, 1'b0},  // R4 equal
        {1'b1, 1'b0, 8'h50, 8'h30, 8'h20, 1'b1, 1'b0},  // R6 sub same signs
        {1'b1, 1'b1, 8'hFF, 8'h01, 8'hFE, 1'b1, 1'b0}   // R3 cin ignored
    };

    task automatic check(input string tag, input logic [W+1:0] act, input logic [W+1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s a=%h b=%h cin=%b sub=%b : got {sum,cout,ovf}=%h expected %h",
                     tag, op_a, op_b, carry_in, sub_sel, act, exp);
        end
    endtask

    task automatic apply(input logic s, input logic c, input logic [W-1:0] a, input logic [W-1:0] b);
        sub_sel  = s;
        carry_in = c;
        op_a     = a;
        op_b     = b;
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 idle state: zero inputs give all-zero outputs
        check("R1 idle", {sum_out, carry_out, ovf_out}, '0);

        for (int v = 0; v < NVEC; v++) begin
            apply(VEC[v][27], VEC[v][26], VEC[v][25:18], VEC[v][17:10]);
            check("R1-R7 vector", {sum_out, carry_out, ovf_out}, VEC[v][9:0]);
        end

        // R3: carry_in toggled in subtract mode leaves every output unchanged
        apply(1'b1, 1'b0, 8'hA5, 8'h3C);
        begin
            logic [W+1:0] ref0;
            ref0 = {sum_out, carry_out, ovf_out};
            apply(1'b1, 1'b1, 8'hA5, 8'h3C);
            check("R3 cin no effect", {sum_out, carry_out, ovf_out}, ref0);
        end

        // Full sweep: R1 R2 R3 R4 R5 R6
        for (int m = 0; m < 3; m++) begin
            for (int a = 0; a < 256; a++) begin
                for (int b = 0; b < 256; b++) begin
                    int sa, sb, sr, ur;
                    logic [W-1:0] es;
                    logic ec, eo;
                    logic s, c;
                    s  = (m == 2);
                    c  = (m == 1);
                    sa = (a >= 128) ? a - 256 : a;
                    sb = (b >= 128) ? b - 256 : b;
                    if (!s) begin
                        ur = a + b + int'(c);
                        es = ur[W-1:0];
                        ec = (ur >= 256);
                        sr = sa + sb + int'(c);
                    end else begin
                        ur = a - b;
                        es = ur[W-1:0];
                        ec = (a >= b);
                        sr = sa - sb;
                    end
                    eo = (sr > 127) || (sr < -128);
                    apply(s, c, W'(a), W'(b));
                    check(s ? "R3 R4 R5 R6 sweep" : "R1 R2 R5 R6 sweep",
                          {sum_out, carry_out, ovf_out}, {es, ec, eo});
                end
            end
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule